// File: doc/BRIEF.md
# Power-On Reset Sequencing Controller

This block takes a chip from power-up to a running system in a fixed order. It waits for the supply to clear its power-on threshold and for the internal regulated supplies to be declared safe. It then asserts the internal system reset, drives the bidirectional active-low reset pin low and enables the clock generator. Next it turns on the system, flash and default-on bus clocks. After that it lets the flash controller out of reset, and on that same step it pulses a strobe that captures the nonvolatile option byte into a register.

Flash initialisation runs while the rest of the chip stays in reset. When initialisation reports done, the block stops driving the pin low. It then waits until the synchronised pin level reads high, so a slow-rising pin or an external pull-down keeps the system in reset. Only then does it enable the core clock and release the system. A low pin level after release, or a loss of supply, sends the block back to the held state, and the whole sequence repeats.

A sticky error flag reports a flash initialisation that never finishes. A data-ready output tells software when restored nonvolatile data may be used.

Top module: `boot_reset_sequencer`

## Requirements
- R1: While `supply_ok` is low, the block is held asynchronously: `sys_rst`=1, `pin_drive_low`=1, `flash_rst`=1, and `clkgen_en`, all clock enables, `opt_load`, `nv_ready` and `flash_timeout_err` are 0. Dropping `supply_ok` at any point returns the block to this state at once.
- R2: With `supply_ok` high and `vreg_safe` low, the block stays in the held state. One clock edge after `vreg_safe` is sampled high, the first sequencing step begins.
- R3: In the first step, `sys_rst`=1, `pin_drive_low`=1 and `clkgen_en`=1. All clock enables are 0, `flash_rst`=1 and `flash_timeout_err` is cleared. The step lasts one cycle.
- R4: In the second step (one cycle), `sys_clk_en`=1 and `flash_clk_en`=1, and `bus_clk_en` equals the `BUS_CLK_DEFAULT_ON` mask (default 4'b1011). `core_clk_en` stays 0 until system release.
- R5: From the third step on, `flash_rst`=0, while `sys_rst`=1 and `pin_drive_low`=1 remain until `flash_done` is sampled high.
- R6: `opt_load` is high for exactly one cycle, the third step. On the edge that ends it, `opt_reg` captures `opt_byte_in`, and `opt_reg` ignores `opt_byte_in` at all other times.
- R7: The edge that samples `flash_done` ends the pin drive (`pin_drive_low`=0). `sys_rst` stays 1 and `core_clk_en` 0 for as long as the pin reads low.
- R8: `pin_in` passes through a two-flop synchroniser. If the pin becomes high between edges k and k+1, `sys_rst` falls and `core_clk_en` rises after edge k+3.
- R9: After release, `nv_ready` is 1 if `nv_restore_en` is 0. Otherwise it rises one edge after `nv_restore_done` is sampled high. It is 0 whenever the system is in reset.
- R10: After release, if the synchronised pin reads low, the block returns to the held state 3 edges after the pin went low, and it then runs the whole sequence again.
- R11: If `flash_done` is not seen during `FLASH_TIMEOUT` edges of the flash wait, `flash_timeout_err` rises after the edge numbered `FLASH_TIMEOUT`. It then stays high until the next first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| supply_ok | input | 1 | Supply above power-on threshold; low acts as asynchronous reset |
| vreg_safe | input | 1 | Internal regulated supplies at a safe level |
| flash_done | input | 1 | Flash initialisation complete |
| pin_in | input | 1 | Sensed level of the active-low reset pin |
| nv_restore_en | input | 1 | Nonvolatile restore feature enabled |
| nv_restore_done | input | 1 | Nonvolatile data restore complete |
| opt_byte_in | input | OPT_W | Option byte value read from nonvolatile memory |
| sys_rst | output | 1 | Internal system reset, active high |
| pin_drive_low | output | 1 | Drive the reset pin low |
| clkgen_en | output | 1 | Clock generator enable, default mode |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| bus_clk_en | output | NUM_BUS_CLK | Bus clock enables |
| flash_rst | output | 1 | Flash controller reset, active high |
| opt_load | output | 1 | One-cycle option byte capture strobe |
| opt_reg | output | OPT_W | Captured option byte |
| nv_ready | output | 1 | Restored nonvolatile data usable |
| flash_timeout_err | output | 1 | Flash initialisation timed out |

## Verification
The bench holds the pin low with an external pull for several cycles after the pin drive ends. A design that released the core clock on the drive release alone, or that skipped the synchroniser, would let `sys_rst` fall early, and the exact release-latency count exposes both faults. It changes `opt_byte_in` after capture and again across a repeated sequence. A capture that is level-driven or missing would show the wrong byte. It pulls the pin low after release and also drops the supply mid-run, so that a design that failed to restart, or kept a stale timeout flag, would break the second sequence. The flash wait is starved past the timeout limit, and the error flag is checked one cycle before and on the limit, which catches off-by-one counters.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    SQ_HOLD  = 3'd0,
    SQ_GEN   = 3'd1,
    SQ_CLKS  = 3'd2,
    SQ_OPT   = 3'd3,
    SQ_FINIT = 3'd4,
    SQ_PINW  = 3'd5,
    SQ_RUN   = 3'd6
  } seq_state_t;
endpackage

// File: rtl/rsq_pin_sync.sv
module rsq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d_i;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rsq_flash_timer.sv
module rsq_flash_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_i,
  input  logic done_i,
  input  logic clr_i,
  output logic err_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      err_o <= 1'b0;
    end else begin
      if (!wait_i) cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
      if (clr_i) err_o <= 1'b0;
      else if (wait_i && !done_i && cnt == LAST) err_o <= 1'b1;
    end
  end

  assert_err_needs_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(wait_i));
  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> err_o);
endmodule

// File: rtl/rsq_out_decode.sv
module rsq_out_decode import rsq_pkg::*; #(
  parameter int NUM_BUS_CLK = 4,
  parameter logic [NUM_BUS_CLK-1:0] BUS_ON = '1
) (
  input  seq_state_t         state_i,
  output logic               sys_rst_o,
  output logic               pin_low_o,
  output logic               clkgen_o,
  output logic               core_o,
  output logic               sys_o,
  output logic               flash_o,
  output logic [NUM_BUS_CLK-1:0] bus_o,
  output logic               frst_o,
  output logic               opt_o
);
  always_comb begin
    sys_rst_o = 1'b1;
    pin_low_o = 1'b1;
    clkgen_o  = 1'b0;
    core_o    = 1'b0;
    sys_o     = 1'b0;
    flash_o   = 1'b0;
    bus_o     = '0;
    frst_o    = 1'b1;
    opt_o     = 1'b0;
    if (state_i != SQ_HOLD) clkgen_o = 1'b1;
    if (state_i inside {SQ_CLKS, SQ_OPT, SQ_FINIT, SQ_PINW, SQ_RUN}) begin
      sys_o   = 1'b1;
      flash_o = 1'b1;
      bus_o   = BUS_ON;
    end
    if (state_i inside {SQ_OPT, SQ_FINIT, SQ_PINW, SQ_RUN}) frst_o = 1'b0;
    if (state_i == SQ_OPT) opt_o = 1'b1;
    if (state_i inside {SQ_PINW, SQ_RUN}) pin_low_o = 1'b0;
    if (state_i == SQ_RUN) begin
      sys_rst_o = 1'b0;
      core_o    = 1'b1;
    end
  end
endmodule

// File: rtl/boot_reset_sequencer.sv
module boot_reset_sequencer import rsq_pkg::*; #(
  parameter int NUM_BUS_CLK = 4,
  parameter logic [NUM_BUS_CLK-1:0] BUS_CLK_DEFAULT_ON = 4'b1011,
  parameter int OPT_W = 8,
  parameter int FLASH_TIMEOUT = 4096,
  parameter int PIN_SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   supply_ok,
  input  logic                   vreg_safe,
  input  logic                   flash_done,
  input  logic                   pin_in,
  input  logic                   nv_restore_en,
  input  logic                   nv_restore_done,
  input  logic [OPT_W-1:0]       opt_byte_in,
  output logic                   sys_rst,
  output logic                   pin_drive_low,
  output logic                   clkgen_en,
  output logic                   core_clk_en,
  output logic                   sys_clk_en,
  output logic                   flash_clk_en,
  output logic [NUM_BUS_CLK-1:0] bus_clk_en,
  output logic                   flash_rst,
  output logic                   opt_load,
  output logic [OPT_W-1:0]       opt_reg,
  output logic                   nv_ready,
  output logic                   flash_timeout_err
);
  seq_state_t state, state_nx;
  logic pin_hi;
  logic nv_seen;

  rsq_pin_sync #(.STAGES(PIN_SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(supply_ok), .d_i(pin_in), .q_o(pin_hi)
  );

  rsq_flash_timer #(.LIMIT(FLASH_TIMEOUT)) u_flash_timer (
    .clk(clk), .rst_n(supply_ok), .wait_i(state == SQ_FINIT),
    .done_i(flash_done), .clr_i(state == SQ_GEN), .err_o(flash_timeout_err)
  );

  rsq_out_decode #(.NUM_BUS_CLK(NUM_BUS_CLK), .BUS_ON(BUS_CLK_DEFAULT_ON)) u_decode (
    .state_i(state), .sys_rst_o(sys_rst), .pin_low_o(pin_drive_low),
    .clkgen_o(clkgen_en), .core_o(core_clk_en), .sys_o(sys_clk_en),
    .flash_o(flash_clk_en), .bus_o(bus_clk_en), .frst_o(flash_rst),
    .opt_o(opt_load)
  );

  always_comb begin
    state_nx = state;
    case (state)
      SQ_HOLD:  if (vreg_safe) state_nx = SQ_GEN;
      SQ_GEN:   state_nx = SQ_CLKS;
      SQ_CLKS:  state_nx = SQ_OPT;
      SQ_OPT:   state_nx = SQ_FINIT;
      SQ_FINIT: if (flash_done) state_nx = SQ_PINW;
      SQ_PINW:  if (pin_hi) state_nx = SQ_RUN;
      SQ_RUN:   if (!pin_hi) state_nx = SQ_HOLD;
      default:  state_nx = SQ_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      state   <= SQ_HOLD;
      opt_reg <= '0;
      nv_seen <= 1'b0;
    end else begin
      state <= state_nx;
      if (opt_load) opt_reg <= opt_byte_in;
      if (state != SQ_RUN) nv_seen <= 1'b0;
      else if (nv_restore_done) nv_seen <= 1'b1;
    end
  end

  assign nv_ready = (state == SQ_RUN) && (!nv_restore_en || nv_seen);

  assert_hold_until_safe_R2: assert property (@(posedge clk) disable iff (!supply_ok)
    (state == SQ_HOLD && !vreg_safe) |=> state == SQ_HOLD);
  assert_flash_wait_holds_R5: assert property (@(posedge clk) disable iff (!supply_ok)
    (state == SQ_FINIT && !flash_done) |=> (sys_rst && pin_drive_low && !flash_rst));
  assert_opt_pulse_R6: assert property (@(posedge clk) disable iff (!supply_ok)
    opt_load |=> !opt_load);
  assert_opt_captured_R6: assert property (@(posedge clk) disable iff (!supply_ok)
    opt_load |=> opt_reg == $past(opt_byte_in));
  assert_no_release_while_low_R7: assert property (@(posedge clk) disable iff (!supply_ok)
    (state == SQ_PINW && !pin_hi) |=> sys_rst);
  assert_ready_only_released_R9: assert property (@(posedge clk) disable iff (!supply_ok)
    nv_ready |-> !sys_rst);
  assert_restart_on_low_R10: assert property (@(posedge clk) disable iff (!supply_ok)
    (state == SQ_RUN && !pin_hi) |=> state == SQ_HOLD);
endmodule

// File: tb/test_boot_reset_sequencer.sv
`timescale 1ns/1ps
module test_boot_reset_sequencer;
  localparam int NB = 4;
  localparam logic [NB-1:0] MASK = 4'b1011;
  localparam int TMO = 20;
  localparam int NROWS = 14;
  // {vreg_safe, flash_done, ext_low} | {sys_rst,pin_low,clkgen,core,sys,flash,bus,frst,opt}
  localparam logic [11:0] VEC [NROWS] = '{
    12'b000_110000010, 12'b100_110000010, 12'b100_111000010, 12'b100_111011110,
    12'b100_111011101, 12'b100_111011100, 12'b111_111011100, 12'b101_101011100,
    12'b101_101011100, 12'b100_101011100, 12'b100_101011100, 12'b100_101011100,
    12'b100_001111100, 12'b100_001111100 };

  logic clk = 1'b0;
  logic supply_ok = 1'b0, vreg_safe = 1'b0, flash_done = 1'b0, ext_low = 1'b0;
  logic nv_restore_en = 1'b0, nv_restore_done = 1'b0;
  logic [7:0] opt_byte_in = 8'hA5;
  logic pin_in;
  logic sys_rst, pin_drive_low, clkgen_en, core_clk_en, sys_clk_en, flash_clk_en;
  logic [NB-1:0] bus_clk_en;
  logic flash_rst, opt_load, nv_ready, flash_timeout_err;
  logic [7:0] opt_reg;
  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;
  assign pin_in = !(pin_drive_low || ext_low);

  boot_reset_sequencer #(.NUM_BUS_CLK(NB), .BUS_CLK_DEFAULT_ON(MASK), .FLASH_TIMEOUT(TMO))
  i_boot_reset_sequencer (
    .clk(clk), .supply_ok(supply_ok), .vreg_safe(vreg_safe), .flash_done(flash_done),
    .pin_in(pin_in), .nv_restore_en(nv_restore_en), .nv_restore_done(nv_restore_done),
    .opt_byte_in(opt_byte_in), .sys_rst(sys_rst), .pin_drive_low(pin_drive_low),
    .clkgen_en(clkgen_en), .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
    .flash_clk_en(flash_clk_en), .bus_clk_en(bus_clk_en), .flash_rst(flash_rst),
    .opt_load(opt_load), .opt_reg(opt_reg), .nv_ready(nv_ready),
    .flash_timeout_err(flash_timeout_err)
  );

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [8:0] outs();
    return {sys_rst, pin_drive_low, clkgen_en, core_clk_en, sys_clk_en, flash_clk_en,
            (bus_clk_en == MASK), flash_rst, opt_load};
  endfunction

  function automatic string row_req(input int r);
    if (r < 2) return "R2";
    if (r == 2) return "R3";
    if (r == 3) return "R4";
    if (r == 4) return "R6";
    if (r < 7) return "R5";
    if (r < 12) return "R7";
    return "R8";
  endfunction

  // from held state with vreg_safe high, stop at first negedge in the flash wait
  task automatic boot_to_finit();
    vreg_safe = 1'b1;
    for (int k = 0; k < 20; k++) begin
      step();
      if (!flash_rst && !opt_load && pin_drive_low) break;
    end
  endtask

  // pulse flash_done, hold pin low externally for e edges, return edges to release
  task automatic release_after(input int e, output int n);
    ext_low = (e > 0);
    flash_done = 1'b1;
    step();
    flash_done = 1'b0;
    n = 0;
    if (e == 0) ext_low = 1'b0;
    for (int k = 0; k < 40; k++) begin
      step();
      n++;
      if (n == e) ext_low = 1'b0;
      if (!sys_rst) break;
    end
  endtask

  initial begin
    int n;
    @(negedge clk);
    // R1: held while supply low
    vreg_safe = 1'b1;
    repeat (5) step();
    check("R1 reset outputs", {23'd0, outs()}, {23'd0, 9'b110000010});
    check("R1 bus/ready/err low", {bus_clk_en, nv_ready, flash_timeout_err}, '0);
    vreg_safe = 1'b0;

    supply_ok = 1'b1;
    for (int r = 0; r < NROWS; r++) begin
      check($sformatf("%s table row %0d", row_req(r), r), {23'd0, outs()}, {23'd0, VEC[r][8:0]});
      {vreg_safe, flash_done, ext_low} = VEC[r][11:9];
      step();
    end
    check("R6 option byte captured", opt_reg, 8'hA5);
    check("R9 ready with restore disabled", nv_ready, 1'b1);
    opt_byte_in = 8'h3C;
    repeat (3) step();
    check("R6 option byte ignored after capture", opt_reg, 8'hA5);

    // R10: pin pulled low after release
    ext_low = 1'b1;
    nv_restore_en = 1'b1;
    step(); step();
    check("R10 still released after 2 edges", sys_rst, 1'b0);
    step();
    check("R10 back in reset after 3 edges", {sys_rst, pin_drive_low, clkgen_en}, 3'b110);
    ext_low = 1'b0;
    boot_to_finit();
    check("R10 resequenced to flash wait", {flash_rst, sys_clk_en, core_clk_en}, 3'b010);
    check("R6 recaptured on new sequence", opt_reg, 8'h3C);
    release_after(5, n);
    check("R8 release latency with pin held 5", n, 8);
    check("R9 not ready before restore", nv_ready, 1'b0);
    nv_restore_done = 1'b1;
    step();
    nv_restore_done = 1'b0;
    check("R9 ready after restore", nv_ready, 1'b1);

    // R1: supply drop mid-run is immediate
    #1 supply_ok = 1'b0;
    #0.5;
    check("R1 supply drop", {23'd0, outs()}, {23'd0, 9'b110000010});
    check("R1 ready cleared", nv_ready, 1'b0);
    @(negedge clk);
    supply_ok = 1'b1;
    // R11: timeout
    boot_to_finit();
    for (int k = 1; k <= TMO; k++) begin
      step();
      if (k == TMO - 1) check("R11 no error before limit", flash_timeout_err, 1'b0);
      if (k == TMO) check("R11 error at limit", flash_timeout_err, 1'b1);
    end
    release_after(0, n);
    check("R8 release latency pin free", n, 3);
    check("R11 error sticky after release", flash_timeout_err, 1'b1);
    ext_low = 1'b1;
    step(); step(); step();
    ext_low = 1'b0;
    step(); step();
    check("R3 error cleared by new sequence", flash_timeout_err, 1'b0);
    check("R4 clocks step core off", {sys_clk_en, core_clk_en, bus_clk_en}, {2'b10, MASK});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end
endmodule